// File: doc/BRIEF.md
# Majority-Stepped Triple-Register Keystream Generator

This block produces a pseudorandom bit stream from three linear feedback shift registers of lengths 17, 18 and 19 that do not all move on every step. Each register has one designated control cell. On each requested step the three control bits go into a two-of-three vote. A register advances only if its own control bit matches the vote result. The registers that lose the vote keep their contents. The output bit is the XOR of the three registers' last cells after the step.

The seeds for all three registers are written together with a load strobe. A seed of all zeros would lock a register, so it is replaced by the value 1. After loading, each assertion of the step strobe produces one output bit one clock later, flagged by a valid signal. A three-bit mask reports which registers advanced on that step. The register lengths, feedback taps and control-cell positions are parameters with fixed defaults.

Top module: `maj_keystream_gen`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `ks_valid` is 0 and `adv_mask` is 0. Every register holds the value 1.
- R2: When `load_en` is high at a rising edge, the registers take `seed_a`, `seed_b` and `seed_c`, even if `step_en` is also high. In the following cycle `ks_valid` is 0 and `adv_mask` is 0.
- R3: An all-zero seed for a register is loaded as the value 1 (only cell 0 set). No register state is ever zero.
- R4: The control bits are cell 8 of register A, cell 9 of register B and cell 9 of register C. All three are taken from the state before the step. The vote is (a&b)^(a&c)^(b&c).
- R5: On a step, a register advances exactly when its control bit equals the vote; the other registers keep their state unchanged.
- R6: Every step advances at least two registers. When all three control bits are equal, all three registers advance.
- R7: On an advance, every cell i moves to cell i+1. Cell 0 receives the XOR of the tap cells: A uses cells 16 and 13 (x^17+x^14+1); B uses cells 17 and 10 (x^18+x^11+1); C uses cells 18, 17, 16 and 13 (x^19+x^18+x^17+x^14+1).
- R8: The cycle after a rising edge with `step_en`=1 and `load_en`=0, `ks_valid` is 1. In that cycle, `ks_bit` is the XOR of cell 16 of A, cell 17 of B and cell 18 of C after the step.
- R9: A rising edge with `step_en`=0 moves no register. In the following cycle `ks_valid` is 0 and `adv_mask` is 0.
- R10: `adv_mask` bit 0 is register A, bit 1 is register B and bit 2 is register C. Each bit is 1 in the cycle after a step in which that register advanced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| load_en | input | 1 | Seed load strobe, overrides stepping |
| seed_a | input | 17 | Seed for register A |
| seed_b | input | 18 | Seed for register B |
| seed_c | input | 19 | Seed for register C |
| step_en | input | 1 | Request one majority-clocked step |
| ks_bit | output | 1 | Keystream bit after the last step |
| ks_valid | output | 1 | High for one cycle after each step |
| adv_mask | output | 3 | Registers that advanced on the last step |

## Verification
The hardest case to reach from the ports is a step on which all three control bits agree. It arises only from particular register contents, while most steps move exactly two registers. The stimulus loads several seeds, including one chosen so that all three control cells start equal. It then runs long directed streams and compares every step with an independent model. It also records whether every advance pattern (each two-register pair and all three) was seen. Idle cycles are placed between steps to show that a stall leaves the stream intact.

// File: rtl/maj_ks_pkg.sv
package maj_ks_pkg;

    localparam int A_LEN = 17;
    localparam int B_LEN = 18;
    localparam int C_LEN = 19;

    localparam logic [A_LEN-1:0] A_TAPS = 17'h12000;
    localparam logic [B_LEN-1:0] B_TAPS = 18'h20400;
    localparam logic [C_LEN-1:0] C_TAPS = 19'h72000;

    localparam int A_CTRL = 8;
    localparam int B_CTRL = 9;
    localparam int C_CTRL = 9;

    localparam int NREG = 3;

    typedef struct packed {
        logic            ks_bit;
        logic            ks_valid;
        logic [NREG-1:0] adv;
    } ks_out_t;

endpackage

// File: rtl/lfsr_stage.sv
module lfsr_stage #(
    parameter int             LEN      = 17,
    parameter logic [LEN-1:0] TAPS     = '0,
    parameter int             CTRL_POS = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           load,
    input  logic [LEN-1:0] seed,
    input  logic           adv,
    output logic           ctrl_bit,
    output logic           next_last
);

    localparam logic [LEN-1:0] ONE = LEN'(1);

    logic [LEN-1:0] state_d, state_q;
    logic           fb;

    always_comb begin
        fb      = ^(state_q & TAPS);
        state_d = state_q;
        if (load) begin
            state_d = (seed == '0) ? ONE : seed;
        end else if (adv) begin
            state_d = {state_q[LEN-2:0], fb};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ONE;
        else        state_q <= state_d;
    end

    assign ctrl_bit  = state_q[CTRL_POS];
    assign next_last = state_d[LEN-1];

endmodule

// File: rtl/maj3_vote.sv
module maj3_vote (
    input  logic [2:0] bits,
    output logic [2:0] agree
);

    logic vote;

    always_comb begin
        vote = (bits[0] & bits[1]) ^ (bits[0] & bits[2]) ^ (bits[1] & bits[2]);
        for (int i = 0; i < 3; i++) begin
            agree[i] = ~(bits[i] ^ vote);
        end
    end

endmodule

// File: rtl/maj_keystream_gen.sv
module maj_keystream_gen
    import maj_ks_pkg::*;
#(
    parameter int               A_W  = A_LEN,
    parameter int               B_W  = B_LEN,
    parameter int               C_W  = C_LEN,
    parameter logic [A_W-1:0]   A_TP = A_TAPS,
    parameter logic [B_W-1:0]   B_TP = B_TAPS,
    parameter logic [C_W-1:0]   C_TP = C_TAPS,
    parameter int               A_CB = A_CTRL,
    parameter int               B_CB = B_CTRL,
    parameter int               C_CB = C_CTRL
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           load_en,
    input  logic [A_W-1:0] seed_a,
    input  logic [B_W-1:0] seed_b,
    input  logic [C_W-1:0] seed_c,
    input  logic           step_en,
    output logic           ks_bit,
    output logic           ks_valid,
    output logic [2:0]     adv_mask
);

    logic [NREG-1:0] cbits;
    logic [NREG-1:0] agree;
    logic [NREG-1:0] adv;
    logic [NREG-1:0] nlast;
    logic            go;
    ks_out_t         out_d, out_q;

    maj3_vote u_vote (
        .bits  (cbits),
        .agree (agree)
    );

    lfsr_stage #(.LEN(A_W), .TAPS(A_TP), .CTRL_POS(A_CB)) u_ra (
        .clk(clk), .rst_n(rst_n), .load(load_en), .seed(seed_a),
        .adv(adv[0]), .ctrl_bit(cbits[0]), .next_last(nlast[0])
    );

    lfsr_stage #(.LEN(B_W), .TAPS(B_TP), .CTRL_POS(B_CB)) u_rb (
        .clk(clk), .rst_n(rst_n), .load(load_en), .seed(seed_b),
        .adv(adv[1]), .ctrl_bit(cbits[1]), .next_last(nlast[1])
    );

    lfsr_stage #(.LEN(C_W), .TAPS(C_TP), .CTRL_POS(C_CB)) u_rc (
        .clk(clk), .rst_n(rst_n), .load(load_en), .seed(seed_c),
        .adv(adv[2]), .ctrl_bit(cbits[2]), .next_last(nlast[2])
    );

    always_comb begin
        go             = step_en & ~load_en;
        adv            = go ? agree : '0;
        out_d          = out_q;
        out_d.ks_valid = go;
        out_d.adv      = adv;
        if (go) out_d.ks_bit = ^nlast;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) out_q <= '0;
        else        out_q <= out_d;
    end

    assign ks_bit   = out_q.ks_bit;
    assign ks_valid = out_q.ks_valid;
    assign adv_mask = out_q.adv;

endmodule

// File: rtl/maj_keystream_chk.sv
module maj_keystream_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       load_en,
    input logic       step_en,
    input logic [2:0] cbits,
    input logic       ks_valid,
    input logic [2:0] adv_mask
);

    // R6
    two_or_more_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ks_valid |-> ($countones(adv_mask) >= 2));

    // R4
    all_equal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ks_valid && ($past(cbits) == 3'b000 || $past(cbits) == 3'b111)) |-> (adv_mask == 3'b111));

    // R9
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ks_valid |-> (adv_mask == 3'b000));

    // R8
    valid_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step_en && !load_en) |=> ks_valid);

    // R2
    load_no_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ks_valid |-> !$past(load_en));

endmodule

module lfsr_stage_chk #(
    parameter int LEN = 17
) (
    input logic           clk,
    input logic           rst_n,
    input logic           load,
    input logic           adv,
    input logic [LEN-1:0] state_q
);

    // R5
    hold_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && !adv) |=> $stable(state_q));

    // R7
    shift_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && adv) |=> (state_q[LEN-1:1] == $past(state_q[LEN-2:0])));

    // R3
    never_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        state_q != '0);

endmodule

bind maj_keystream_gen maj_keystream_chk u_chk (
    .clk(clk), .rst_n(rst_n), .load_en(load_en), .step_en(step_en),
    .cbits(cbits), .ks_valid(ks_valid), .adv_mask(adv_mask)
);

bind lfsr_stage lfsr_stage_chk #(.LEN(LEN)) u_schk (
    .clk(clk), .rst_n(rst_n), .load(load), .adv(adv), .state_q(state_q)
);

// File: tb/sim_maj_keystream_gen.sv
module sim_maj_keystream_gen;

    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        load_en = 1'b0;
    logic        step_en = 1'b0;
    logic [16:0] seed_a = '0;
    logic [17:0] seed_b = '0;
    logic [18:0] seed_c = '0;
    logic        ks_bit;
    logic        ks_valid;
    logic [2:0]  adv_mask;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    logic [16:0] ma;
    logic [17:0] mb;
    logic [18:0] mc;
    bit seen_011, seen_101, seen_110, seen_111;

    always #(CLK_P/2) clk = ~clk;

    maj_keystream_gen u0 (
        .clk(clk), .rst_n(rst_n), .load_en(load_en),
        .seed_a(seed_a), .seed_b(seed_b), .seed_c(seed_c),
        .step_en(step_en), .ks_bit(ks_bit), .ks_valid(ks_valid), .adv_mask(adv_mask)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    // model of one step: R4 vote, R5 selection, R7 feedback, R8 output
    task automatic step_once(input bit en);
        logic [2:0] c, e;
        logic       v, ek;
        step_en = en;
        c = {mc[9], mb[9], ma[8]};
        v = (c[0] & c[1]) | (c[0] & c[2]) | (c[1] & c[2]);
        e = 3'b000;
        if (en) begin
            for (int i = 0; i < 3; i++) e[i] = (c[i] == v);
            if (e[0]) ma = {ma[15:0], ma[16] ^ ma[13]};
            if (e[1]) mb = {mb[16:0], mb[17] ^ mb[10]};
            if (e[2]) mc = {mc[17:0], mc[18] ^ mc[17] ^ mc[16] ^ mc[13]};
        end
        ek = ma[16] ^ mb[17] ^ mc[18];
        @(negedge clk);
        step_en = 1'b0;
        if (en) begin
            chk(ks_valid == 1'b1, "R8 valid", 32'(ks_valid), 32'd1);
            chk(adv_mask == e, "R5/R10 adv_mask", 32'(adv_mask), 32'(e));
            chk($countones(adv_mask) >= 2, "R6 two or more", 32'(adv_mask), 32'(e));
            chk(ks_bit == ek, "R7/R8 ks_bit", 32'(ks_bit), 32'(ek));
            if (e == 3'b011) seen_011 = 1;
            if (e == 3'b101) seen_101 = 1;
            if (e == 3'b110) seen_110 = 1;
            if (e == 3'b111) seen_111 = 1;
        end else begin
            chk(ks_valid == 1'b0 && adv_mask == 3'b000, "R9 idle",
                32'({ks_valid, adv_mask}), 32'd0);
        end
    endtask

    task automatic load_seeds(input logic [16:0] a, input logic [17:0] b,
                              input logic [18:0] c, input bit with_step);
        load_en = 1'b1;
        step_en = with_step;
        seed_a = a; seed_b = b; seed_c = c;
        ma = (a == '0) ? 17'd1 : a;
        mb = (b == '0) ? 18'd1 : b;
        mc = (c == '0) ? 19'd1 : c;
        @(negedge clk);
        load_en = 1'b0;
        step_en = 1'b0;
        chk(ks_valid == 1'b0 && adv_mask == 3'b000, "R2 load quiet",
            32'({ks_valid, adv_mask}), 32'd0);
    endtask

    task automatic t_reset();
        chk(ks_valid == 1'b0, "R1 ks_valid", 32'(ks_valid), 32'd0);
        chk(adv_mask == 3'b000, "R1 adv_mask", 32'(adv_mask), 32'd0);
        ma = 17'd1; mb = 18'd1; mc = 19'd1;
        for (int i = 0; i < 20; i++) step_once(1'b1);   // R1 reset value 1 in every register
    endtask

    task automatic t_stream();
        load_seeds(17'h1A5C3, 18'h2F0E1, 19'h5B7D2, 1'b0);
        for (int i = 0; i < 600; i++) step_once(1'b1);
        load_seeds(17'h00100, 18'h00200, 19'h00200, 1'b0);  // all control cells 1
        for (int i = 0; i < 300; i++) step_once(1'b1);
        chk(seen_011 && seen_101 && seen_110 && seen_111, "R6 patterns seen",
            32'({seen_111, seen_110, seen_101, seen_011}), 32'hF);
    endtask

    task automatic t_zero_seed();
        load_seeds(17'h0, 18'h0, 19'h0, 1'b0);   // R3 loads as 1
        for (int i = 0; i < 200; i++) step_once(1'b1);
    endtask

    task automatic t_load_priority();
        load_seeds(17'h0F0F0, 18'h3C3C3, 19'h12345, 1'b1);  // R2 load beats step
        for (int i = 0; i < 100; i++) step_once(1'b1);
    endtask

    task automatic t_idle();
        load_seeds(17'h15555, 18'h0AAAA, 19'h6DB6D, 1'b0);
        for (int i = 0; i < 200; i++) step_once((i % 3) != 1);  // R9 stalls keep state
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_stream();
        t_zero_seed();
        t_load_priority();
        t_idle();
        finish_run();
    end

    initial begin
        #(CLK_P * 100000);
        checks++;
        errors++;
        $display("FAIL watchdog actual=hung expected=done");
        finish_run();
    end

endmodule